// File: doc/BRIEF.md
# I2C Register Target

This block is an I2C target that lets an external controller read and write a small internal register space. It runs entirely on a fast system clock and oversamples the two bus lines. START, repeated START and STOP are recovered from the sampled lines. The 7-bit device address is compared against a fixed 6-bit upper part, given as a parameter, plus a least significant bit taken from a strap input. SDA is never driven high: the block only pulls the line low through an open-drain enable.

A write transfer carries a sub-address byte after the device address. Its low seven bits load a register pointer, and its top bit enables pointer auto-increment. Any bytes that follow are written to the register space through a one-cycle write strobe. A read starts with a write of the sub-address. The controller then issues a repeated START and the address with the read bit set. The target then returns bytes from the pointer for as long as the controller acknowledges them.

The register space sits outside the block behind a plain synchronous port made of address, write data, write strobe and read data. Read data may arrive in the same cycle as the address or one cycle after it. Ten-bit addressing, general call, clock stretching and arbitration between several controllers are not part of the block.

Top module: `i2c_reg_target`

## Requirements
- R1: START (SDA falls while SCL is high) sets `bus_busy` to 1, and STOP (SDA rises while SCL is high) clears it.
- R2: The first byte after a START is taken as {address[6:0], direction}, where direction 1 means read. The target acknowledges only when address[6:1] equals `ADDR_HI` and address[0] equals `addr_lsb_strap`. It acknowledges by asserting `sda_pull` through the high phase of the ninth SCL pulse.
- R3: After an address mismatch, the target never pulls SDA and never strobes `reg_we` until the next START.
- R4: In a write, the byte after the address is the sub-address. Bits 6:0 load the register pointer, bit 7 sets auto-increment, and the byte is acknowledged.
- R5: Every later write byte, received MSB first, is acknowledged and produces exactly one single-cycle `reg_we` pulse, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte. The pulse occurs only in the acknowledge slot of a write byte.
- R6: With sub-address bit 7 at 0, the pointer does not move for the whole transfer, for writes and for reads.
- R7: With sub-address bit 7 at 1, the pointer advances by one after each byte written or read, wrapping from 127 to 0.
- R8: After a repeated START and an address with the read bit set, the target shifts out `reg_rdata` at the pointer, MSB first, and sends the next byte after each controller acknowledge.
- R9: A controller not-acknowledge after a read byte ends the read. SDA stays released until the next START.
- R10: A repeated START returns the target to the address phase and keeps the register pointer.
- R11: During and right after reset, `sda_pull`, `reg_we` and `bus_busy` are 0.
- R12: `sda_pull` changes only while the synchronized SCL is low, except when a START or STOP releases it. Data bits therefore stay stable while SCL is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| addr_lsb_strap | input | 1 | Level of the least significant device address bit |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain enable) |
| bus_busy | output | 1 | High from START until STOP |
| reg_addr | output | PTR_W | Register pointer presented to the register space |
| reg_wdata | output | 8 | Write data for the register space |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Read data at `reg_addr` (0 or 1 cycle latency) |

## Verification
The bench covers several corner cases:
- A burst that crosses pointer 127. A design with the wrong pointer width or a saturating pointer would write the second byte to 128 or back to 127 instead of 0.
- A write of one byte followed by a repeated START read. A design that clears the pointer on the repeated START would return register 0 rather than the incremented pointer.
- Address mismatch and a flipped strap level. A design that compares only six bits, or ignores the strap, would acknowledge the wrong address and corrupt registers.
- Reads ending on a not-acknowledge. A design that keeps driving would hold SDA low and block the STOP.
- Fixed-pointer bursts, which catch a design that increments regardless of bit 7.

// File: rtl/i2c_tgt_pkg.sv
// Shared definitions for the I2C register target.
// Assumes byte-wide data on the bus; pointer width is set by the top.
package i2c_tgt_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    // Protocol phases of the target engine.
    typedef enum logic [3:0] {
        T_IDLE,
        T_ADDR,
        T_ADDR_ACK,
        T_SUB,
        T_SUB_ACK,
        T_WR,
        T_WR_ACK,
        T_RD,
        T_RD_ACK,
        T_IGNORE
    } tgt_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
// Synchronizes one asynchronous bus line into the clk domain and
// produces single-cycle rise and fall pulses.
// Assumes the line idles high, so the chain resets to 1.
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic level_o,
    output logic rise_o,
    output logic fall_o
);

    logic [STAGES-1:0] chain;
    logic              prev;

    // Shift the raw line through the synchronizer chain and keep one older copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chain <= '1;
            prev  <= 1'b1;
        end else begin
            chain <= {chain[STAGES-2:0], line_i};
            prev  <= chain[STAGES-1];
        end
    end

    assign level_o = chain[STAGES-1];
    assign rise_o  = level_o & ~prev;
    assign fall_o  = ~level_o & prev;

endmodule

// File: rtl/i2c_bus_cond.sv
// Recovers START and STOP from synchronized lines and tracks bus occupancy.
// Assumes both lines go through synchronizers of equal depth.
module i2c_bus_cond (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_lvl,
    input  logic sda_rise,
    input  logic sda_fall,
    output logic start_p,
    output logic stop_p,
    output logic busy_o
);

    assign start_p = sda_fall & scl_lvl;
    assign stop_p  = sda_rise & scl_lvl;

    // Busy flag: set by any START, cleared by STOP.
    always_ff @(posedge clk) begin
        if (!rst_n)       busy_o <= 1'b0;
        else if (stop_p)  busy_o <= 1'b0;
        else if (start_p) busy_o <= 1'b1;
    end

endmodule

// File: rtl/i2c_tgt_engine.sv
// Byte-level protocol engine: address match, sub-address, data writes,
// data reads with controller acknowledge, pointer handling.
// Assumes scl edge pulses and sda level come from equal-depth synchronizers
// and that reg_rdata is valid within one cycle of reg_addr.
module i2c_tgt_engine
    import i2c_tgt_pkg::*;
#(
    parameter logic [5:0] ADDR_HI = 6'b101101,
    parameter int         PTR_W   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              sda_lvl,
    input  logic              start_p,
    input  logic              stop_p,
    input  logic              strap,
    input  logic [BYTE_W-1:0] rdata_i,
    output logic              pull_o,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [BYTE_W-1:0] wdata_o,
    output logic              we_o,
    output tgt_state_t        state_o
);

    localparam logic [CNT_W-1:0] CNT_ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(BYTE_W);
    localparam logic [PTR_W-1:0] PTR_ONE  = {{(PTR_W-1){1'b0}}, 1'b1};

    tgt_state_t        state;
    logic [CNT_W-1:0]  cnt;
    logic [BYTE_W-1:0] rx;
    logic [BYTE_W-1:0] tx;
    logic              pull;
    logic [PTR_W-1:0]  ptr;
    logic              inc_en;
    logic              rd_dir;
    logic              mack;
    logic              we_q;
    logic [BYTE_W-1:0] wd_q;
    logic              byte_end;
    logic              addr_hit;

    assign byte_end = scl_fall && (cnt == CNT_FULL);
    assign addr_hit = (rx[BYTE_W-1:1] == {ADDR_HI, strap});

    // Protocol sequencer with bit counter, shift registers and pointer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= T_IDLE;
            cnt    <= '0;
            rx     <= '0;
            tx     <= '0;
            pull   <= 1'b0;
            ptr    <= '0;
            inc_en <= 1'b0;
            rd_dir <= 1'b0;
            mack   <= 1'b0;
            we_q   <= 1'b0;
            wd_q   <= '0;
        end else begin
            we_q <= 1'b0;
            if (we_q && inc_en) ptr <= ptr + PTR_ONE;
            if (stop_p) begin
                state <= T_IDLE;
                pull  <= 1'b0;
            end else if (start_p) begin
                state <= T_ADDR;
                cnt   <= '0;
                pull  <= 1'b0;
            end else begin
                case (state)
                    T_ADDR, T_SUB, T_WR: begin
                        if (scl_rise) begin
                            rx  <= {rx[BYTE_W-2:0], sda_lvl};
                            cnt <= cnt + CNT_ONE;
                        end else if (byte_end) begin
                            if (state == T_ADDR) begin
                                if (addr_hit) begin
                                    pull   <= 1'b1;
                                    rd_dir <= rx[0];
                                    state  <= T_ADDR_ACK;
                                end else begin
                                    state  <= T_IGNORE;
                                end
                            end else if (state == T_SUB) begin
                                ptr    <= rx[PTR_W-1:0];
                                inc_en <= rx[BYTE_W-1];
                                pull   <= 1'b1;
                                state  <= T_SUB_ACK;
                            end else begin
                                we_q  <= 1'b1;
                                wd_q  <= rx;
                                pull  <= 1'b1;
                                state <= T_WR_ACK;
                            end
                        end
                    end
                    T_ADDR_ACK, T_SUB_ACK, T_WR_ACK: begin
                        if (scl_fall) begin
                            cnt  <= '0;
                            pull <= 1'b0;
                            if (state == T_ADDR_ACK && rd_dir) begin
                                tx    <= rdata_i;
                                pull  <= ~rdata_i[BYTE_W-1];
                                state <= T_RD;
                                if (inc_en) ptr <= ptr + PTR_ONE;
                            end else if (state == T_ADDR_ACK) begin
                                state <= T_SUB;
                            end else begin
                                state <= T_WR;
                            end
                        end
                    end
                    T_RD: begin
                        if (scl_rise) begin
                            cnt <= cnt + CNT_ONE;
                        end else if (byte_end) begin
                            pull  <= 1'b0;
                            state <= T_RD_ACK;
                        end else if (scl_fall) begin
                            tx   <= {tx[BYTE_W-2:0], 1'b0};
                            pull <= ~tx[BYTE_W-2];
                        end
                    end
                    T_RD_ACK: begin
                        if (scl_rise) begin
                            mack <= ~sda_lvl;
                        end else if (scl_fall) begin
                            cnt <= '0;
                            if (mack) begin
                                tx    <= rdata_i;
                                pull  <= ~rdata_i[BYTE_W-1];
                                state <= T_RD;
                                if (inc_en) ptr <= ptr + PTR_ONE;
                            end else begin
                                pull  <= 1'b0;
                                state <= T_IGNORE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign pull_o  = pull;
    assign ptr_o   = ptr;
    assign wdata_o = wd_q;
    assign we_o    = we_q;
    assign state_o = state;

endmodule

// File: rtl/i2c_reg_target.sv
// Top of the I2C register target: line synchronizers, bus condition
// detector and protocol engine. Assumes clk is at least ~20x the SCL rate
// and that SDA is wired-AND outside (sda_pull = 1 pulls low).
module i2c_reg_target
    import i2c_tgt_pkg::*;
#(
    parameter logic [5:0] ADDR_HI     = 6'b101101,
    parameter int         PTR_W       = 7,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              addr_lsb_strap,
    output logic              sda_pull,
    output logic              bus_busy,
    output logic [PTR_W-1:0]  reg_addr,
    output logic [BYTE_W-1:0] reg_wdata,
    output logic              reg_we,
    input  logic [BYTE_W-1:0] reg_rdata
);

    localparam int N_LINES = 2;
    localparam int L_SCL   = 0;
    localparam int L_SDA   = 1;

    logic [N_LINES-1:0] raw;
    logic [N_LINES-1:0] lvl;
    logic [N_LINES-1:0] rise;
    logic [N_LINES-1:0] fall;
    logic               start_p;
    logic               stop_p;
    tgt_state_t         eng_state;

    assign raw[L_SCL] = scl_i;
    assign raw[L_SDA] = sda_i;

    for (genvar g = 0; g < N_LINES; g++) begin : g_sync
        i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk    (clk),
            .rst_n  (rst_n),
            .line_i (raw[g]),
            .level_o(lvl[g]),
            .rise_o (rise[g]),
            .fall_o (fall[g])
        );
    end

    i2c_bus_cond u_cond (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_lvl (lvl[L_SCL]),
        .sda_rise(rise[L_SDA]),
        .sda_fall(fall[L_SDA]),
        .start_p (start_p),
        .stop_p  (stop_p),
        .busy_o  (bus_busy)
    );

    i2c_tgt_engine #(.ADDR_HI(ADDR_HI), .PTR_W(PTR_W)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_rise(rise[L_SCL]),
        .scl_fall(fall[L_SCL]),
        .sda_lvl (lvl[L_SDA]),
        .start_p (start_p),
        .stop_p  (stop_p),
        .strap   (addr_lsb_strap),
        .rdata_i (reg_rdata),
        .pull_o  (sda_pull),
        .ptr_o   (reg_addr),
        .wdata_o (reg_wdata),
        .we_o    (reg_we),
        .state_o (eng_state)
    );

endmodule

// File: rtl/i2c_reg_target_chk.sv
// Property checker for i2c_reg_target, attached by bind.
module i2c_reg_target_chk
    import i2c_tgt_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_lvl,
    input logic       start_p,
    input logic       stop_p,
    input logic       busy,
    input logic       sda_pull,
    input logic       reg_we,
    input tgt_state_t state
);

    p_busy_set_r1: assert property (@(posedge clk) disable iff (!rst_n)
        start_p && !stop_p |=> busy);

    p_busy_clr_r1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_p |=> !busy);

    p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state == T_IGNORE |-> !sda_pull && !reg_we);

    p_we_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    p_we_slot_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> state == T_WR_ACK);

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !sda_pull && !reg_we);

    p_pull_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sda_pull) && !$past(start_p) && !$past(stop_p)) |-> !$past(scl_lvl));

endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .scl_lvl (lvl[0]),
    .start_p (start_p),
    .stop_p  (stop_p),
    .busy    (bus_busy),
    .sda_pull(sda_pull),
    .reg_we  (reg_we),
    .state   (eng_state)
);

// File: tb/tb_i2c_reg_target.sv
// Directed bench: one task per scenario, each checking its own results.
module tb_i2c_reg_target;

    localparam logic [5:0] ADDR_HI = 6'b101101;
    localparam int         Q       = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       sda_m = 1'b1;
    logic       strap = 1'b0;
    logic       sda_pull, bus_busy, reg_we;
    logic [6:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    logic       sda_line;
    logic [7:0] mem [128];
    logic [7:0] exp_m [128];
    int         n_chk = 0, n_bad = 0, we_cnt = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    assign sda_line = sda_m & ~sda_pull;

    i2c_reg_target #(.ADDR_HI(ADDR_HI)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .addr_lsb_strap(strap), .sda_pull(sda_pull), .bus_busy(bus_busy),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
        .reg_rdata(reg_rdata)
    );

    // Register space model with one cycle read latency.
    always @(posedge clk) begin
        if (reg_we) begin
            mem[reg_addr] <= reg_wdata;
            we_cnt <= we_cnt + 1;
        end
        reg_rdata <= mem[reg_addr];
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1; scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq();
    endtask

    task automatic bus_rstart();
        sda_m = 1; wq(); scl = 1; wq(); sda_m = 0; wq(); scl = 0; wq();
    endtask

    task automatic bus_stop();
        sda_m = 0; wq(); scl = 1; wq(); sda_m = 1; wq(); wq();
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wq(); scl = 1; wq(); wq(); scl = 0; wq();
        end
        sda_m = 1; wq(); scl = 1; wq(); ack = !sda_line; wq(); scl = 0; wq();
    endtask

    task automatic rd_byte(input bit ack, output logic [7:0] b, output bit glitch);
        sda_m = 1; glitch = 0;
        for (int i = 7; i >= 0; i--) begin
            wq(); scl = 1; wq(); b[i] = sda_line; wq();
            if (sda_line !== b[i]) glitch = 1;
            scl = 0;
        end
        sda_m = ack ? 1'b0 : 1'b1;
        wq(); scl = 1; wq(); wq(); scl = 0; wq(); sda_m = 1;
    endtask

    function automatic logic [7:0] adb(input bit lsb, input bit rd);
        return {ADDR_HI, lsb, rd};
    endfunction

    // Write a sequence of bytes after a sub-address in one transfer.
    task automatic wr_xfer(input logic [7:0] sub, input logic [7:0] d[4], input int n, input string req);
        bit a;
        bus_start();
        chk(bus_busy === 1'b1, "R1 busy after START", bus_busy, 1);
        wr_byte(adb(strap, 0), a); chk(a, "R2 address ack", a, 1);
        wr_byte(sub, a);           chk(a, "R4 sub-address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            wr_byte(d[i], a); chk(a, {req, " data ack"}, a, 1);
        end
        bus_stop();
        chk(bus_busy === 1'b0, "R1 busy after STOP", bus_busy, 0);
    endtask

    task automatic t_reset();
        chk(sda_pull === 1'b0, "R11 sda_pull in reset", sda_pull, 0);
        chk(reg_we === 1'b0, "R11 reg_we in reset", reg_we, 0);
        chk(bus_busy === 1'b0, "R11 bus_busy in reset", bus_busy, 0);
    endtask

    task automatic t_write_fixed();
        logic [7:0] d[4] = '{8'hA5, 8'h3C, 8'h00, 8'h00};
        int w0 = we_cnt;
        wr_xfer(8'h05, d, 2, "R5");
        exp_m[5] = 8'h3C;
        chk(mem[5] === exp_m[5], "R6 fixed pointer write", mem[5], exp_m[5]);
        chk(mem[6] === exp_m[6], "R6 neighbour untouched", mem[6], exp_m[6]);
        chk(we_cnt - w0 == 2, "R5 one strobe per byte", we_cnt - w0, 2);
    endtask

    task automatic t_write_burst();
        logic [7:0] d[4] = '{8'h11, 8'h22, 8'h33, 8'h44};
        wr_xfer(8'h90, d, 4, "R5");
        for (int i = 0; i < 4; i++) begin
            exp_m[16 + i] = d[i];
            chk(mem[16 + i] === d[i], "R7 burst write", mem[16 + i], d[i]);
        end
    endtask

    task automatic t_wrap();
        logic [7:0] d[4] = '{8'hC1, 8'hC2, 8'h00, 8'h00};
        wr_xfer(8'hFF, d, 2, "R7");
        exp_m[127] = 8'hC1; exp_m[0] = 8'hC2;
        chk(mem[127] === 8'hC1, "R7 write at 127", mem[127], 8'hC1);
        chk(mem[0] === 8'hC2, "R7 wrap to 0", mem[0], 8'hC2);
    endtask

    // Set pointer by write, repeated START, read n bytes (last one nacked).
    task automatic rd_xfer(input logic [7:0] sub, input int n, input int step, input string req);
        bit a, g;
        logic [7:0] b;
        int p = sub[6:0];
        bus_start();
        wr_byte(adb(strap, 0), a); chk(a, "R2 address ack", a, 1);
        wr_byte(sub, a);           chk(a, "R4 sub-address ack", a, 1);
        bus_rstart();
        wr_byte(adb(strap, 1), a); chk(a, "R8 read address ack", a, 1);
        for (int i = 0; i < n; i++) begin
            rd_byte(i != n - 1, b, g);
            chk(b === exp_m[p], req, b, exp_m[p]);
            chk(!g, "R12 data stable while SCL high", g, 0);
            p = (p + step) % 128;
        end
        chk(sda_pull === 1'b0, "R9 released after nack", sda_pull, 0);
        chk(sda_line === 1'b1, "R9 line high after nack", sda_line, 1);
        bus_stop();
    endtask

    task automatic t_read_burst();
        rd_xfer(8'h90, 4, 1, "R8 burst read");
    endtask

    task automatic t_read_fixed();
        rd_xfer(8'h05, 3, 0, "R6 fixed pointer read");
    endtask

    task automatic t_wrap_read();
        rd_xfer(8'hFF, 2, 1, "R7 read wraps to 0");
    endtask

    task automatic t_rstart_keeps();
        bit a, g;
        logic [7:0] b;
        bus_start();
        wr_byte(adb(strap, 0), a);
        wr_byte(8'h85, a);
        wr_byte(8'h77, a); chk(a, "R5 data ack", a, 1);
        exp_m[5] = 8'h77;
        bus_rstart();
        wr_byte(adb(strap, 1), a); chk(a, "R10 address ack after repeated START", a, 1);
        rd_byte(0, b, g);
        chk(b === exp_m[6], "R10 pointer kept across repeated START", b, exp_m[6]);
        bus_stop();
    endtask

    task automatic t_mismatch();
        bit a;
        int w0 = we_cnt;
        bus_start();
        wr_byte({ADDR_HI ^ 6'b000100, strap, 1'b0}, a); chk(!a, "R3 no ack on mismatch", a, 0);
        wr_byte(8'h05, a); chk(!a, "R3 sub ignored", a, 0);
        wr_byte(8'hEE, a); chk(!a, "R3 data ignored", a, 0);
        bus_stop();
        chk(we_cnt == w0, "R3 no write strobe", we_cnt - w0, 0);
        chk(mem[5] === exp_m[5], "R3 register unchanged", mem[5], exp_m[5]);
    endtask

    task automatic t_strap();
        bit a;
        strap = 1; wq();
        bus_start();
        wr_byte(adb(1'b0, 0), a); chk(!a, "R2 strap 1 rejects lsb 0", a, 0);
        bus_stop();
        bus_start();
        wr_byte(adb(1'b1, 0), a); chk(a, "R2 strap 1 accepts lsb 1", a, 1);
        bus_stop();
        strap = 0; wq();
    endtask

    initial begin
        for (int i = 0; i < 128; i++) begin
            mem[i] = 8'((i * 37 + 11) ^ 8'h5A);
            exp_m[i] = 8'((i * 37 + 11) ^ 8'h5A);
        end
        repeat (3) @(negedge clk);
        t_reset();
        repeat (7) @(negedge clk);
        rst_n = 1;
        repeat (5) @(negedge clk);
        t_reset();
        t_write_fixed();
        t_write_burst();
        t_wrap();
        t_read_burst();
        t_read_fixed();
        t_wrap_read();
        t_rstart_keeps();
        t_mismatch();
        t_strap();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule